// File: doc/BRIEF.md
# Descriptor-ring receive DMA channel

This block moves received Ethernet frames into memory without help from a processor. Software builds a closed ring of descriptors. Each descriptor is four 32-bit words on a 16-byte boundary. Word 0 (offset 0x0) is the control word, word 1 (offset 0x4) links to the next descriptor, word 2 (offset 0x8) points to a word-aligned data buffer, and word 3 (offset 0xC) receives the completion status. Software writes the address of the first descriptor, sets a poll interval and pulses the start command.

From then on the engine reads each descriptor in turn and waits for a frame. It packs the incoming bytes into 32-bit words and writes them into the buffer. When the buffer is done it writes the status word and follows the link to the next descriptor. A descriptor whose hold flag is set stops the engine where it stands. The engine then reads that descriptor again every time the poll interval runs out, until software clears the flag. A frame that arrives while the engine is stopped or held is thrown away whole and counted.

The memory side is a single word-wide request/acknowledge master. The frame side is a byte stream with start and end markers and a ready signal.

Top module: `rxring_dma`

## Requirements
- R1: After reset the engine issues no memory request, `drop_count` is 0, and the frame input is ready, so that bytes are discarded.
- R2: A `cmd_start` pulse in the idle state makes the engine read the descriptor at the base address. The base is loaded by `base_wr`, and its low 4 bits are forced to zero. The engine reads the control word at +0x0, then the link at +0x4, then the buffer pointer at +0x8.
- R3: If bit 31 (hold) of the control word is set, the engine reads neither the link nor the pointer, and it writes nothing. It reads the same control word again about `poll_ivl*POLL_SCALE` cycles later, and it resumes once the bit reads as clear.
- R4: Frame bytes go into the buffer little-endian. Byte k of a buffer is stored at pointer+4*(k/4), in lane k%4, which is bits 8*(k%4)+7 down to 8*(k%4). A word is written once lane 3 is filled, or the frame ends, or the buffer fills. `mem_be` marks the filled lanes.
- R5: When a buffer is finished, the engine writes the status word at descriptor+0xC with all byte lanes enabled. The status word holds bit 31 = complete (always 1), bit 30 = the buffer holds the frame's first byte, bit 29 = the buffer holds the frame's last byte, and bits 16:0 = the number of bytes stored in that buffer. That count includes the trailing 4 check-sequence bytes of the frame.
- R6: After writing status, the engine fetches the descriptor named by the link word. The last descriptor of the ring links back to the first.
- R7: The capacity of a buffer is given by bits 21:0 of the control word. A frame longer than that capacity fills the buffer and closes it with end-of-packet clear and the count equal to the capacity. The frame then continues at lane 0 of the next descriptor's buffer, whose status has start-of-packet clear.
- R8: A frame that starts while the engine is idle, or held between frames, is consumed to its end marker and never written to memory. Each such frame increments `drop_count` by one.
- R9: `cmd_off` returns the engine to idle. Any memory access in progress completes first. A partially packed word is discarded, and no status is written for the aborted buffer. The remaining bytes of that frame, which carry no start marker, are discarded without counting.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr`, `mem_wdata` and `mem_be` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start pulse, honoured only when idle |
| cmd_off | input | 1 | Stop pulse |
| base_wr | input | 1 | Load the first-descriptor address |
| base_data | input | 32 | First-descriptor address |
| poll_ivl | input | POLL_W | Hold re-read interval, in units of POLL_SCALE cycles |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte-lane enables for writes |
| mem_ack | input | 1 | Request completes at this edge |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| in_valid | input | 1 | Frame byte valid |
| in_sop | input | 1 | Byte is the first of a frame |
| in_eop | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| in_ready | output | 1 | Byte is taken when in_valid and in_ready |
| drop_count | output | DROP_W | Number of frames dropped whole |

## Verification
On every cycle, the assertions check the stability of the memory handshake and the alignment of descriptor addresses. They also check that a set hold bit sends the engine into the held state, and that an off command with no access pending leaves it idle. They check that each status write has the complete bit set, that it stays within the buffer capacity and that a split buffer is full. Finally, they check that no data word is written while a frame is being dropped. Other behaviours can only be shown by the bench's scenarios against its scoreboard of expected memory writes. These are the byte packing and lane enables, the exact status contents, the walk around the ring and its wrap, and the splitting of an oversize frame. They also include the re-read interval of a held descriptor, the whole-frame drops in idle and in hold, and the abort that leaves no status behind.

// File: rtl/rxring_dma.sv
module rxring_dma #(
  parameter int POLL_W     = 8,
  parameter int POLL_SCALE = 16,
  parameter int DROP_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_off,
  input  logic              base_wr,
  input  logic [31:0]       base_data,
  input  logic [POLL_W-1:0] poll_ivl,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic [DROP_W-1:0] drop_count
);

  localparam int CW = 17;
  localparam int TW = POLL_W + $clog2(POLL_SCALE) + 1;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_HOLD, S_READY, S_RECV, S_WDATA, S_WSTAT} st_t;

  st_t             st;
  logic [31:0]     base_q, cur, nxt, bufp, wbuf;
  logic [CW-1:0]   lim, cnt;
  logic [3:0]      wbe;
  logic [1:0]      widx;
  logic [TW-1:0]   tmr;
  logic            cont, first, lastf, fullf, dropping, off_pend;
  logic [DROP_W-1:0] drop_q;

  wire take      = in_valid && in_ready;
  wire off_req   = cmd_off || off_pend;
  wire idle_like = (st == S_IDLE) || (st == S_HOLD && !cont);
  wire data_take = take && !dropping && (st == S_RECV || (st == S_READY && in_sop));
  wire [CW-1:0] cnt_nx = cnt + 1'b1;
  wire [1:0]    lane   = cnt[1:0];
  wire [TW-1:0] tmr_load = TW'(poll_ivl) * TW'(POLL_SCALE);
  wire [31:0]   status = {1'b1, first, lastf, 12'd0, cnt};

  assign in_ready   = dropping || idle_like || st == S_READY || st == S_RECV;
  assign mem_req    = (st == S_FETCH) || (st == S_WDATA) || (st == S_WSTAT);
  assign mem_we     = (st == S_WDATA) || (st == S_WSTAT);
  assign mem_addr   = (st == S_WDATA) ? bufp :
                      (st == S_WSTAT) ? cur + 32'd12 : cur + {28'd0, widx, 2'b00};
  assign mem_wdata  = (st == S_WDATA) ? wbuf : status;
  assign mem_be     = (st == S_WDATA) ? wbe : 4'hF;
  assign drop_count = drop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_wr) begin
      base_q <= {base_data[31:4], 4'h0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dropping <= 1'b0;
      drop_q   <= '0;
    end else if (take && dropping) begin
      if (in_eop) dropping <= 1'b0;
    end else if (take && idle_like && in_sop) begin
      drop_q <= drop_q + 1'b1;
      if (!in_eop) dropping <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cur <= '0; nxt <= '0; bufp <= '0; wbuf <= '0;
      lim <= '0; cnt <= '0; wbe <= '0; widx <= '0; tmr <= '0;
      cont <= 1'b0; first <= 1'b0; lastf <= 1'b0; fullf <= 1'b0; off_pend <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          off_pend <= 1'b0;
          if (cmd_start && !cmd_off) begin
            cur  <= base_q;
            widx <= 2'd0;
            cont <= 1'b0;
            st   <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (mem_ack) begin
            if (off_req) begin
              st <= S_IDLE;
            end else begin
              case (widx)
                2'd0: begin
                  if (mem_rdata[31]) begin
                    tmr <= tmr_load;
                    st  <= S_HOLD;
                  end else begin
                    lim  <= (|mem_rdata[21:CW]) ? '1 : mem_rdata[CW-1:0];
                    widx <= 2'd1;
                  end
                end
                2'd1: begin
                  nxt  <= mem_rdata;
                  widx <= 2'd2;
                end
                default: begin
                  bufp  <= {mem_rdata[31:2], 2'b00};
                  cnt   <= '0;
                  wbuf  <= '0;
                  wbe   <= '0;
                  widx  <= 2'd0;
                  first <= !cont;
                  st    <= cont ? S_RECV : S_READY;
                end
              endcase
            end
          end else if (cmd_off) begin
            off_pend <= 1'b1;
          end
        end
        S_HOLD: begin
          if (off_req) st <= S_IDLE;
          else if (tmr == '0) begin
            widx <= 2'd0;
            st   <= S_FETCH;
          end else tmr <= tmr - 1'b1;
        end
        S_READY, S_RECV: begin
          if (off_req) begin
            st <= S_IDLE;
          end else if (data_take) begin
            wbuf[{lane, 3'b000} +: 8] <= in_data;
            wbe[lane] <= 1'b1;
            cnt   <= cnt_nx;
            lastf <= in_eop;
            fullf <= (cnt_nx == lim);
            st    <= (lane == 2'd3 || in_eop || cnt_nx == lim) ? S_WDATA : S_RECV;
          end
        end
        S_WDATA: begin
          if (mem_ack) begin
            if (off_req) st <= S_IDLE;
            else begin
              bufp <= bufp + 32'd4;
              wbuf <= '0;
              wbe  <= '0;
              st   <= (lastf || fullf) ? S_WSTAT : S_RECV;
            end
          end else if (cmd_off) begin
            off_pend <= 1'b1;
          end
        end
        S_WSTAT: begin
          if (mem_ack) begin
            if (off_req) st <= S_IDLE;
            else begin
              cur  <= nxt;
              widx <= 2'd0;
              cont <= !lastf;
              st   <= S_FETCH;
            end
          end else if (cmd_off) begin
            off_pend <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r10_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata) && $stable(mem_be)));

  a_r2_desc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr[1:0] == 2'b00 && mem_addr[3:2] != 2'b11));

  a_r3_hold_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH && widx == 2'd0 && mem_ack && mem_rdata[31] && !off_pend && !cmd_off)
      |=> (st == S_HOLD));

  a_r9_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_off && !mem_req) |=> (st == S_IDLE));

  a_r5_status_complete: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_addr[3:0] == 4'hC && st == S_WSTAT)
      |-> (mem_wdata[31] && mem_be == 4'hF));

  a_r7_split_full: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WSTAT && !mem_wdata[29]) |-> (mem_wdata[CW-1:0] == lim));

  a_r7_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WSTAT) |-> (mem_wdata[CW-1:0] <= lim));

  a_r8_drop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    dropping |-> !(mem_req && mem_we && st == S_WDATA));

endmodule

// File: tb/tb_rxring_dma.sv
module tb_rxring_dma;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cmd_start = 0, cmd_off = 0, base_wr = 0;
  logic [31:0] base_data = 0;
  logic [7:0]  poll_ivl = 8'd7;
  logic        mem_req, mem_we, mem_ack, in_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        in_valid = 0, in_sop = 0, in_eop = 0;
  logic [7:0]  in_data = 0;
  logic [15:0] drop_count;

  rxring_dma dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_off(cmd_off),
    .base_wr(base_wr), .base_data(base_data), .poll_ivl(poll_ivl),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
    .in_ready(in_ready), .drop_count(drop_count));

  logic [31:0] mem [0:255];
  logic        poke_en = 0;
  logic [31:0] poke_addr = 0, poke_data = 0;

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else mem_ack <= mem_req && !mem_ack;
    mem_rdata <= mem[mem_addr[9:2]];
    if (mem_req && mem_we && mem_ack) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end else if (poke_en) begin
      mem[poke_addr[9:2]] <= poke_data;
    end
  end

  int checks = 0, fails = 0, cyc = 0, wr_total = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] exp_a[$], exp_d[$];
  logic [3:0]  exp_b[$];

  bit          arm_rd = 0;
  logic [31:0] first_rd = 0;
  int          prev_rd0 = -1, last_gap = 0;

  task automatic chk(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      if (mem_we) begin
        wr_total++;
        if (exp_a.size() == 0) begin
          chk(0, "R8/R9 unexpected write", mem_addr, 0);
        end else begin
          logic [31:0] ea, ed; logic [3:0] eb;
          ea = exp_a.pop_front(); ed = exp_d.pop_front(); eb = exp_b.pop_front();
          chk(mem_addr == ea, "R4/R5/R6 write address", mem_addr, ea);
          chk(mem_wdata == ed, "R4/R5/R7 write data", mem_wdata, ed);
          chk(mem_be == eb, "R4 byte enables", mem_be, eb);
        end
      end else begin
        if (arm_rd) begin first_rd = mem_addr; arm_rd = 0; end
        if (mem_addr == 32'h100) begin
          if (prev_rd0 >= 0) last_gap = cyc - prev_rd0;
          prev_rd0 = cyc;
        end
      end
    end
  end

  logic [31:0] d_addr[3] = '{32'h100, 32'h110, 32'h120};
  logic [31:0] d_buf[3]  = '{32'h200, 32'h280, 32'h300};
  int          d_max[3]  = '{64, 10, 64};
  int          idx = 0;

  function automatic void push(logic [31:0] a, logic [31:0] d, logic [3:0] b);
    exp_a.push_back(a); exp_d.push_back(d); exp_b.push_back(b);
  endfunction

  function automatic void push_frame(int n, int seed);
    int pos = 0; bit sop = 1; logic [31:0] w = 0; logic [3:0] be = 0;
    for (int i = 0; i < n; i++) begin
      int lane; bit last, full;
      lane = pos % 4;
      w[8*lane +: 8] = 8'(seed + i);
      be[lane] = 1'b1;
      pos++;
      last = (i == n - 1);
      full = (pos == d_max[idx]);
      if (lane == 3 || last || full) begin
        push(d_buf[idx] + 32'((pos - 1) / 4 * 4), w, be);
        w = 0; be = 0;
      end
      if (last || full) begin
        push(d_addr[idx] + 32'd12, {1'b1, sop, last, 12'd0, 17'(pos)}, 4'hF);
        sop = 0; pos = 0; idx = (idx + 1) % 3;
      end
    end
  endfunction

  task automatic send(int n, int seed, bit sopf, bit eopf);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = 8'(seed + i);
      in_sop = sopf && (i == 0); in_eop = eopf && (i == n - 1);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  task automatic poke(logic [31:0] a, logic [31:0] d);
    @(negedge clk); poke_en = 1; poke_addr = a; poke_data = d;
    @(negedge clk); poke_en = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); arm_rd = 1; cmd_start = 1;
    @(negedge clk); cmd_start = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int w0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    for (int k = 0; k < 3; k++) begin
      mem[d_addr[k][9:2]]     = 32'(d_max[k]);
      mem[d_addr[k][9:2] + 1] = d_addr[(k + 1) % 3];
      mem[d_addr[k][9:2] + 2] = d_buf[k];
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(mem_req == 0, "R1 no request after reset", mem_req, 0);
    chk(drop_count == 0, "R1 drop count after reset", drop_count, 0);
    chk(in_ready == 1, "R1 input ready when idle", in_ready, 1);

    send(6, 8'h10, 1, 1);
    repeat (5) @(negedge clk);
    chk(drop_count == 1, "R8 frame dropped while idle", drop_count, 1);
    chk(wr_total == 0, "R8 no write while idle", wr_total, 0);

    @(negedge clk); base_wr = 1; base_data = 32'h107;
    @(negedge clk); base_wr = 0;
    pulse_start();
    repeat (20) @(negedge clk);
    chk(first_rd == 32'h100, "R2 first read at aligned base", first_rd, 32'h100);

    push_frame(13, 8'h20);
    send(13, 8'h20, 1, 1);
    repeat (20) @(negedge clk);
    chk(exp_a.size() == 0, "R4 R5 13-byte frame fully written", exp_a.size(), 0);

    poke(32'h100, 32'h8000_0040);
    push_frame(23, 8'h40);
    send(23, 8'h40, 1, 1);
    repeat (20) @(negedge clk);
    chk(exp_a.size() == 0, "R7 R6 split frame across two buffers", exp_a.size(), 0);

    send(6, 8'h60, 1, 1);
    repeat (5) @(negedge clk);
    chk(drop_count == 2, "R8 frame dropped while held", drop_count, 2);
    w0 = wr_total;
    repeat (300) @(negedge clk);
    chk(wr_total == w0, "R3 no write while held", wr_total, w0);
    chk(last_gap >= 112 && last_gap <= 116, "R3 re-read interval", last_gap, 114);

    poke(32'h100, 32'h0000_0040);
    repeat (150) @(negedge clk);
    push_frame(8, 8'h70);
    send(8, 8'h70, 1, 1);
    repeat (40) @(negedge clk);
    chk(exp_a.size() == 0, "R3 R6 frame stored after release", exp_a.size(), 0);

    push(32'h280, 32'h83828180, 4'hF);
    send(5, 8'h80, 1, 0);
    repeat (5) @(negedge clk);
    @(negedge clk); cmd_off = 1;
    @(negedge clk); cmd_off = 0;
    repeat (10) @(negedge clk);
    w0 = wr_total;
    send(4, 8'h85, 0, 1);
    repeat (10) @(negedge clk);
    chk(exp_a.size() == 0, "R9 abort keeps only the full word", exp_a.size(), 0);
    chk(wr_total == w0, "R9 no status after off", wr_total, w0);
    chk(drop_count == 2, "R9 tail bytes not counted", drop_count, 2);
    send(3, 8'h90, 1, 1);
    repeat (5) @(negedge clk);
    chk(drop_count == 3, "R8 R9 frame dropped after off", drop_count, 3);

    idx = 0;
    pulse_start();
    repeat (20) @(negedge clk);
    chk(first_rd == 32'h100, "R2 R9 restart reads base", first_rd, 32'h100);
    push_frame(4, 8'hA0);
    send(4, 8'hA0, 1, 1);
    repeat (20) @(negedge clk);
    chk(exp_a.size() == 0, "R4 R5 4-byte frame", exp_a.size(), 0);
    chk(mem[32'h200 >> 2] == 32'hA3A2A1A0, "R4 buffer contents", mem[32'h200 >> 2], 32'hA3A2A1A0);
    chk(mem_req == 0 || mem_we == 0, "R10 engine quiet after frame", mem_req, 0);

    finish_run();
  end
endmodule